// File: doc/BRIEF.md
# HDLC Receive Line Monitor

This block watches the serial receive line of an HDLC controller one bit at a time. A bit is taken only on clocks where the bit-enable input is high. The block finds flag octets, abort runs and an idle line. Between flags it drops the zeros that the transmitter inserted for transparency, and it counts the remaining bits so that it can tell whether a frame closed on a whole number of octets.

Next to the bit path it follows the modem carrier-detect input, which is active low. It reports the carrier as a live level and also latches every change of it. Two strobes from outside the block are latched into the same status word: one from the CRC checker and one from the receive FIFO (a write while full).

Software clears a latched bit by writing a 1 to its position. A per-bit enable mask selects which latched bits drive the single interrupt line.

Top module: `hdlc_rx_monitor`

## Requirements
- R1: Status bit 0 (flag seen) sets on the clock edge that takes in the final 0 of the bit pattern 0,1,1,1,1,1,1,0 (in time order), counting raw line bits.
- R2: On a clock with bitEn low, rxBit is ignored: no run, flag, count or frame state advances.
- R3: Status bit 3 (idle) sets on the 15th consecutive received 1. It is set again on every further 1. A received 0 stops the re-setting.
- R4: Status bit 4 (abort) sets on the 7th consecutive received 1, once per run. It always ends the current frame.
- R5: The abort contributes to irq only when it occurs inside a frame. A frame is in progress once at least 8 bits have been counted after an opening flag. An abort outside a frame leaves irq low even when bit 4 is enabled.
- R6: Status bit 1 reads the inverse of dcdN two clocks after dcdN changes. It cannot be cleared and never drives irq.
- R7: Status bit 2 (carrier change) sets three clocks after any transition of dcdN.
- R8: Status bit 6 (non-octet) sets when a flag closes a frame in progress and the number of counted bits before the flag is not a multiple of 8.
- R9: Between an opening flag and the next flag or abort, a 0 received right after exactly five 1s is dropped and not counted.
- R10: Status bit 5 sets on the clock after crcErrIn is high. Status bit 7 sets on the clock after fifoOvfIn is high.
- R11: When clrWe is high, every latched bit whose clrData bit is 1 clears on the next edge. Bits written 0 keep their value. A set event in the same cycle wins over the clear.
- R12: irq is the OR of the latched bits ANDed with intEnMask, with bit 1 excluded and bit 4 gated as in R5. It follows a mask change in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Qualifies rxBit on this clock |
| rxBit | input | 1 | Received line bit |
| dcdN | input | 1 | Carrier detect, active low, asynchronous |
| crcErrIn | input | 1 | CRC error strobe from the CRC checker |
| fifoOvfIn | input | 1 | Strobe for a FIFO write while full |
| clrWe | input | 1 | Write strobe for clearing status |
| clrData | input | 8 | One bit per status position; a 1 clears that bit |
| intEnMask | input | 8 | Interrupt enable per status bit |
| status | output | 8 | Status word (bit map in R1 to R10) |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the following relations:
- a rising flag bit comes from a received 0, and a rising idle bit from a received 1;
- the live carrier bit follows dcdN through the two-clock delay;
- the strobe inputs always latch;
- a clear without a competing set takes effect;
- irq stays low under an all-zero mask.

The stuffing removal, the octet alignment of closing flags, the in-frame gating of the abort interrupt and the ignored bits under a low bitEn depend on multi-bit history. Only the bench scenarios show these, each compared cycle by cycle against the behavioural model.

// File: rtl/hdlc_rx_monitor_pkg.sv
package hdlc_rx_monitor_pkg;
  localparam int STAT_W    = 8;
  localparam int BYTE_BITS = 8;
  localparam int OCT_W     = $clog2(BYTE_BITS);
  localparam int STUFF_RUN = 5;
  localparam logic [7:0] FLAG_PAT = 8'b0111_1110;

  // status bit positions
  localparam int B_FLAG     = 0;
  localparam int B_DCD_LIVE = 1;
  localparam int B_DCD_CHG  = 2;
  localparam int B_IDLE     = 3;
  localparam int B_ABORT    = 4;
  localparam int B_CRC      = 5;
  localparam int B_NOCT     = 6;
  localparam int B_OVR      = 7;

  // datapath observations, already qualified by bitEn where relevant
  typedef struct packed {
    logic bitStep;
    logic flagHit;
    logic abortHit;
    logic idleHit;
    logic stuffZero;
    logic octLast;
    logic dcdEdge;
  } rxObs_t;

  // control strobes to the datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } rxCtl_t;

  typedef enum logic [1:0] {HUNT, OPEN, FRAME} frameSt_t;
endpackage

// File: rtl/hdlc_rx_datapath.sv
module hdlc_rx_datapath
  import hdlc_rx_monitor_pkg::*;
#(
  parameter int IDLE_RUN  = 15,
  parameter int ABORT_RUN = 7
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   bitEn,
  input  logic   rxBit,
  input  logic   dcdN,
  input  rxCtl_t ctl,
  output rxObs_t obs,
  output logic   dcdLive
);
  localparam int RUN_W = $clog2(IDLE_RUN + 1);
  localparam int PAT_W = $bits(FLAG_PAT);

  logic [PAT_W-1:0] shiftReg;
  logic [RUN_W-1:0] runCnt;
  logic [OCT_W-1:0] octCnt;
  logic dcdS1, dcdS2, dcdPrev;

  // raw line history and run of ones
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '1;
      runCnt   <= '0;
    end else if (bitEn) begin
      shiftReg <= {shiftReg[PAT_W-2:0], rxBit};
      if (!rxBit)
        runCnt <= '0;
      else if (runCnt != RUN_W'(IDLE_RUN))
        runCnt <= runCnt + 1'b1;
    end
  end

  // destuffed bit counter modulo one octet
  always_ff @(posedge clk) begin
    if (!rstN)
      octCnt <= '0;
    else if (ctl.cntClr)
      octCnt <= '0;
    else if (ctl.cntInc)
      octCnt <= (octCnt == OCT_W'(BYTE_BITS - 1)) ? '0 : octCnt + 1'b1;
  end

  // carrier detect synchronizer and edge history
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dcdS1   <= 1'b1;
      dcdS2   <= 1'b1;
      dcdPrev <= 1'b1;
    end else begin
      dcdS1   <= dcdN;
      dcdS2   <= dcdS1;
      dcdPrev <= dcdS2;
    end
  end

  always_comb begin
    obs.bitStep   = bitEn;
    obs.flagHit   = bitEn && ({shiftReg[PAT_W-2:0], rxBit} == FLAG_PAT);
    obs.abortHit  = bitEn && rxBit && (runCnt == RUN_W'(ABORT_RUN - 1));
    obs.idleHit   = bitEn && rxBit && (runCnt >= RUN_W'(IDLE_RUN - 1));
    obs.stuffZero = bitEn && !rxBit && (runCnt == RUN_W'(STUFF_RUN));
    obs.octLast   = (octCnt == OCT_W'(BYTE_BITS - 1));
    obs.dcdEdge   = (dcdS2 != dcdPrev);
  end

  assign dcdLive = !dcdS2;
endmodule

// File: rtl/hdlc_rx_status.sv
module hdlc_rx_status
  import hdlc_rx_monitor_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rxObs_t            obs,
  input  logic              dcdLive,
  input  logic              crcErrIn,
  input  logic              fifoOvfIn,
  input  logic              clrWe,
  input  logic [STAT_W-1:0] clrData,
  input  logic [STAT_W-1:0] intEnMask,
  output rxCtl_t            ctl,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  frameSt_t frameSt, frameNext;
  logic [STAT_W-1:0] latched, setVec, clrVec, irqVec;
  logic abortArm, armSet;

  // frame tracking and set events
  always_comb begin
    frameNext = frameSt;
    setVec    = '0;
    armSet    = 1'b0;
    ctl       = '0;
    setVec[B_DCD_CHG] = obs.dcdEdge;
    setVec[B_CRC]     = crcErrIn;
    setVec[B_OVR]     = fifoOvfIn;
    setVec[B_IDLE]    = obs.idleHit;
    if (obs.flagHit) begin
      setVec[B_FLAG] = 1'b1;
      setVec[B_NOCT] = (frameSt == FRAME) && !obs.octLast;
      frameNext      = OPEN;
      ctl.cntClr     = 1'b1;
    end else if (obs.abortHit) begin
      setVec[B_ABORT] = 1'b1;
      armSet          = (frameSt == FRAME);
      frameNext       = HUNT;
    end else if (obs.bitStep && frameSt != HUNT && !obs.stuffZero) begin
      ctl.cntInc = 1'b1;
      if (frameSt == OPEN && obs.octLast)
        frameNext = FRAME;
    end
  end

  assign clrVec = clrWe ? clrData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameSt  <= HUNT;
      latched  <= '0;
      abortArm <= 1'b0;
    end else begin
      frameSt  <= frameNext;
      latched  <= (latched & ~clrVec) | setVec;
      abortArm <= (abortArm & ~clrVec[B_ABORT]) | armSet;
    end
  end

  always_comb begin
    status             = latched;
    status[B_DCD_LIVE] = dcdLive;
    irqVec             = latched & intEnMask;
    irqVec[B_DCD_LIVE] = 1'b0;
    irqVec[B_ABORT]    = abortArm & intEnMask[B_ABORT];
  end

  assign irq = |irqVec;
endmodule

// File: rtl/hdlc_rx_monitor.sv
module hdlc_rx_monitor
  import hdlc_rx_monitor_pkg::*;
#(
  parameter int IDLE_RUN  = 15,
  parameter int ABORT_RUN = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              rxBit,
  input  logic              dcdN,
  input  logic              crcErrIn,
  input  logic              fifoOvfIn,
  input  logic              clrWe,
  input  logic [STAT_W-1:0] clrData,
  input  logic [STAT_W-1:0] intEnMask,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  rxObs_t obs;
  rxCtl_t ctl;
  logic   dcdLive;

  hdlc_rx_datapath #(.IDLE_RUN(IDLE_RUN), .ABORT_RUN(ABORT_RUN)) dp (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxBit(rxBit), .dcdN(dcdN),
    .ctl(ctl), .obs(obs), .dcdLive(dcdLive)
  );

  hdlc_rx_status st (
    .clk(clk), .rstN(rstN), .obs(obs), .dcdLive(dcdLive),
    .crcErrIn(crcErrIn), .fifoOvfIn(fifoOvfIn), .clrWe(clrWe),
    .clrData(clrData), .intEnMask(intEnMask), .ctl(ctl),
    .status(status), .irq(irq)
  );
endmodule

// File: rtl/hdlc_rx_monitor_chk.sv
module hdlc_rx_monitor_chk
  import hdlc_rx_monitor_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              bitEn,
  input logic              rxBit,
  input logic              dcdN,
  input logic              crcErrIn,
  input logic              fifoOvfIn,
  input logic              clrWe,
  input logic [STAT_W-1:0] clrData,
  input logic [STAT_W-1:0] intEnMask,
  input logic [STAT_W-1:0] status,
  input logic              irq
);
  logic [1:0] cycCnt;

  always_ff @(posedge clk) begin
    if (!rstN)
      cycCnt <= '0;
    else if (cycCnt != 2'd3)
      cycCnt <= cycCnt + 1'b1;
  end

  p_flag_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[B_FLAG]) |-> ($past(bitEn) && !$past(rxBit)));

  p_idle_ones_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[B_IDLE]) |-> ($past(bitEn) && $past(rxBit)));

  p_live_dcd_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cycCnt == 2'd3) |-> (status[B_DCD_LIVE] == !$past(dcdN, 2)));

  p_crc_latch_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((cycCnt != 2'd0) && $past(crcErrIn)) |-> status[B_CRC]);

  p_clear_ovf_r11: assert property (@(posedge clk) disable iff (!rstN)
    (clrWe && clrData[B_OVR] && !fifoOvfIn) |=> !status[B_OVR]);

  p_irq_mask_r12: assert property (@(posedge clk) disable iff (!rstN)
    (intEnMask == '0) |-> !irq);
endmodule

bind hdlc_rx_monitor hdlc_rx_monitor_chk chk (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxBit(rxBit), .dcdN(dcdN),
  .crcErrIn(crcErrIn), .fifoOvfIn(fifoOvfIn), .clrWe(clrWe),
  .clrData(clrData), .intEnMask(intEnMask), .status(status), .irq(irq)
);

// File: tb/hdlc_rx_monitor_test.sv
module hdlc_rx_monitor_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0, rxBit = 1'b1, dcdN = 1'b1;
  logic crcErrIn = 1'b0, fifoOvfIn = 1'b0, clrWe = 1'b0;
  logic [7:0] clrData = '0, intEnMask = '0;
  logic [7:0] status;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hdlc_rx_monitor uut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxBit(rxBit), .dcdN(dcdN),
    .crcErrIn(crcErrIn), .fifoOvfIn(fifoOvfIn), .clrWe(clrWe),
    .clrData(clrData), .intEnMask(intEnMask), .status(status), .irq(irq)
  );

  // behavioural reference model
  bit [7:0] mSt;
  bit [7:0] mHist;
  int mRun, mCnt, mFrame;
  bit mArm, mS1, mS2, mP;

  always @(posedge clk) begin
    bit [7:0] setV;
    int oldRun;
    bit isFlag;
    if (!rstN) begin
      mSt = 0; mHist = 8'hFF; mRun = 0; mCnt = 0; mFrame = 0;
      mArm = 0; mS1 = 1; mS2 = 1; mP = 1;
    end else begin
      setV = 0;
      if (mS2 != mP) setV[2] = 1;
      mP = mS2; mS2 = mS1; mS1 = dcdN;
      if (crcErrIn) setV[5] = 1;
      if (fifoOvfIn) setV[7] = 1;
      if (bitEn) begin
        mHist = {mHist[6:0], rxBit};
        isFlag = (mHist == 8'b0111_1110);
        oldRun = mRun;
        mRun = rxBit ? ((mRun < 15) ? mRun + 1 : 15) : 0;
        if (rxBit && mRun >= 15) setV[3] = 1;
        if (isFlag) begin
          setV[0] = 1;
          if (mFrame == 2 && ((mCnt - 7) % 8) != 0) setV[6] = 1;
          mFrame = 1; mCnt = 0;
        end else if (rxBit && oldRun == 6) begin
          setV[4] = 1;
          if (mFrame == 2) mArm = 1;
          else if (clrWe && clrData[4]) mArm = 0;
          mFrame = 0;
        end else if (mFrame != 0 && !(!rxBit && oldRun == 5)) begin
          mCnt++;
          if (mFrame == 1 && mCnt >= 8) mFrame = 2;
        end
      end
      if (clrWe) begin
        mSt = mSt & ~clrData;
        if (clrData[4] && !(setV[4] && mArm)) mArm = 0;
      end
      mSt = mSt | setV;
      mSt[1] = !mS2;
    end
  end

  function automatic bit modelIrq();
    bit [7:0] v;
    v = mSt & intEnMask;
    v[1] = 0;
    v[4] = mArm & intEnMask[4];
    return |v;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, 5 ns after the falling edge
  always @(posedge clk) begin
    #15;
    if (!done) begin
      check(status[0] == mSt[0], "R1 flag", status[0], mSt[0]);
      check(status[1] == mSt[1], "R6 live carrier", status[1], mSt[1]);
      check(status[2] == mSt[2], "R7 carrier change", status[2], mSt[2]);
      check(status[3] == mSt[3], "R3 idle", status[3], mSt[3]);
      check(status[4] == mSt[4], "R4 abort", status[4], mSt[4]);
      check(status[5] == mSt[5], "R10 crc", status[5], mSt[5]);
      check(status[6] == mSt[6], "R8 non-octet", status[6], mSt[6]);
      check(status[7] == mSt[7], "R10 overrun", status[7], mSt[7]);
      check(irq == modelIrq(), "R12 irq", irq, modelIrq());
    end
  end

  task automatic finishUp();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finishUp();
  end

  int txOnes = 0;

  task automatic sendBit(bit b);
    @(negedge clk);
    bitEn = 1; rxBit = b;
  endtask

  task automatic settle();
    @(negedge clk);
    bitEn = 0; clrWe = 0; crcErrIn = 0; fifoOvfIn = 0;
    #1;
  endtask

  task automatic sendFlag();
    sendBit(0);
    for (int i = 0; i < 6; i++) sendBit(1);
    sendBit(0);
    txOnes = 0;
  endtask

  // data bits with zero insertion after five ones
  task automatic sendData(logic [31:0] d, int n);
    for (int i = 0; i < n; i++) begin
      sendBit(d[i]);
      txOnes = d[i] ? txOnes + 1 : 0;
      if (txOnes == 5) begin
        sendBit(0);
        txOnes = 0;
      end
    end
  endtask

  task automatic writeClear(logic [7:0] m);
    @(negedge clk);
    bitEn = 0; clrWe = 1; clrData = m;
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    check(status == 8'h00 && irq == 0, "R11 reset state", status, 0);

    // R1 R2: flag pattern while bitEn low is ignored
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      bitEn = 0; rxBit = (i == 0 || i == 7) ? 0 : 1;
    end
    settle();
    check(status[0] == 0, "R2 ignored flag", status[0], 0);

    // R3 R4 R5: idle line outside a frame, abort bit enabled
    intEnMask = 8'h10;
    for (int i = 0; i < 20; i++) sendBit(1);
    settle();
    check(status[4] == 1, "R4 abort run", status[4], 1);
    check(status[3] == 1, "R3 idle run", status[3], 1);
    check(irq == 0, "R5 abort outside frame", irq, 0);

    // R11: write of zeros keeps bits, write of ones clears them
    writeClear(8'h00);
    check(status[4:3] == 2'b11, "R11 zero write", status[4:3], 3);
    writeClear(8'h18);
    check(status[4:3] == 2'b00, "R11 one write", status[4:3], 0);

    // R3 R11: clear during a continued idle run loses to re-set
    @(negedge clk);
    bitEn = 1; rxBit = 1; clrWe = 1; clrData = 8'h08;
    settle();
    check(status[3] == 1, "R11 set wins over clear", status[3], 1);
    writeClear(8'hFF);

    // R1 R9 R8: aligned 16-bit frame with stuffed zero
    sendFlag();
    settle();
    check(status[0] == 1, "R1 flag seen", status[0], 1);
    sendFlag();
    sendData(32'h0000_F81F, 16);
    sendFlag();
    settle();
    check(status[6] == 0, "R9 stuffed zero not counted", status[6], 0);
    writeClear(8'hFF);

    // R8: 12-bit frame closes off octet boundary
    sendFlag();
    sendData(32'h0000_0A53, 12);
    sendFlag();
    settle();
    check(status[6] == 1, "R8 non-octet close", status[6], 1);
    writeClear(8'hFF);

    // R5: abort inside a frame raises irq; bitEn gaps inside the frame
    intEnMask = 8'h10;
    sendFlag();
    for (int i = 0; i < 10; i++) begin
      sendBit(i[0]);
      @(negedge clk) bitEn = 0;
    end
    for (int i = 0; i < 7; i++) sendBit(1);
    settle();
    check(irq == 1, "R5 abort in frame", irq, 1);
    writeClear(8'h10);
    check(irq == 0, "R12 irq after clear", irq, 0);

    // R6 R7: carrier toggles, live bit excluded from irq
    intEnMask = 8'h02;
    @(negedge clk) dcdN = 0;
    repeat (2) @(posedge clk);
    #15;
    check(status[1] == 1, "R6 live after two clocks", status[1], 1);
    @(posedge clk); #15;
    check(status[2] == 1, "R7 change latched", status[2], 1);
    check(irq == 0, "R6 no live irq", irq, 0);
    writeClear(8'h02);
    check(status[1] == 1, "R6 live not clearable", status[1], 1);
    intEnMask = 8'h04;
    #1;
    check(irq == 1, "R12 change irq", irq, 1);
    @(negedge clk) dcdN = 1;
    repeat (4) @(negedge clk);
    writeClear(8'hFF);

    // R10: external strobes latch
    @(negedge clk) crcErrIn = 1; fifoOvfIn = 1;
    settle();
    check(status[7] == 1 && status[5] == 1, "R10 strobes", status, 8'hA0);
    intEnMask = 8'hFF;
    #1;
    check(irq == 1, "R12 full mask", irq, 1);
    writeClear(8'hFF);

    repeat (3) @(negedge clk);
    finishUp();
  end
endmodule